// File: doc/BRIEF.md
# Eight-Source Interrupt Status Controller

This block gathers eight interrupt sources from a radio front end into a single active-low request line for a host processor. Each source sets one bit of an eight-bit status word. The request line is pulled low for as long as any bit is set. The host collects the word through a one-cycle read strobe, which the serial link logic issues when it shifts the status out.

Each source has its own qualifying enables and its own clear rule:
- Transmit-ready and receive-threshold bits are withdrawn by data movement or when their path is switched off.
- The external bit tracks a pin.
- Every other bit holds until the host has read it.

The analog parts and the serial link are outside the block. They reach it as plain digital pulses, levels and a 4-bit supply code.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rstN` is low, `statusOut` and `rdData` are 0 and `irqN` is 1.
- R2: `irqN` is 0 exactly when at least one bit of `statusOut` is 1.
- R3: Bit 0 (transmit ready) is set one edge after `txEmptyEvt` while `txEn` and `txChainEn` are both 1. It is cleared by `txWrite`, or when either of those enables is 0.
- R4: Bit 1 (receive threshold) is set one edge after `rxLevelEvt` while `fifoEn` and `rxChainEn` are both 1. It is cleared by `rxDrained`, or when either of those enables is 0.
- R5: Bit 2 (reset detected) is set by `porPulse` or `swResetPulse`. A status read is the only thing that clears it.
- R6: Bit 3 (transmit underrun) is set by `txUnderEvt` under the R3 enables. Bit 4 (receive overflow) is set by `rxOverEvt` under the R4 enables. Both clear on read.
- R7: Bit 5 (wake timer) is set by `wakeEvt` only while `wakeEn` is 1, and clears on read.
- R8: Bit 6 (external) equals `extMode & extPin` as sampled at the previous edge. It has no latching.
- R9: Bit 7 (low supply) is set while `battEn` is 1 and `supplyLevel < battThresh`, both compared as 4-bit unsigned values. It clears on read.
- R10: A `statusRd` high at an edge loads `rdData` with the status word as it stood before that edge. At the next edge, the clear-on-read bits (2, 3, 4, 5, 7) that were captured are cleared. Bits that were not captured are kept.
- R11: When a set condition and a clear condition for the same bit occur at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEn | input | 1 | Transmit data path enable |
| txChainEn | input | 1 | Transmitter power enable |
| fifoEn | input | 1 | Receive FIFO enable |
| rxChainEn | input | 1 | Receiver power enable |
| wakeEn | input | 1 | Wake timer enable |
| battEn | input | 1 | Low-supply detector enable |
| extMode | input | 1 | Pin is used as external interrupt |
| txEmptyEvt | input | 1 | Transmit register became empty |
| txUnderEvt | input | 1 | Transmit underrun event |
| txWrite | input | 1 | Host wrote transmit data |
| rxLevelEvt | input | 1 | Receive FIFO reached threshold |
| rxOverEvt | input | 1 | Receive FIFO overflow event |
| rxDrained | input | 1 | Threshold amount read out of FIFO |
| porPulse | input | 1 | Supply-triggered reset seen |
| swResetPulse | input | 1 | Software reset issued |
| wakeEvt | input | 1 | Wake interval elapsed |
| extPin | input | 1 | External interrupt pin level, active high |
| supplyLevel | input | 4 | Quantized supply reading |
| battThresh | input | 4 | Low-supply threshold code |
| statusRd | input | 1 | Status read strobe |
| irqN | output | 1 | Interrupt request, active low |
| statusOut | output | 8 | Live status word |
| rdData | output | 8 | Word captured by the last read |

## Verification
On every cycle, the assertions check four things:
- a set strobe always lands in the status bit;
- a read captures the pre-edge word;
- the reset-detect bit only falls two edges after a read;
- the external bit tracks its qualified pin and the wake bit rises only from a qualified event.

Some behaviour shows only across the bench's scenarios:
- the per-source enable and clear rules interacting over long random runs;
- bits set after a capture surviving the clear;
- the full 16-by-16 sweep of the supply comparison;
- the request line agreeing with the word.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N = 8;

  localparam int TX_RDY  = 0;
  localparam int RX_THR  = 1;
  localparam int RST_DET = 2;
  localparam int TX_UND  = 3;
  localparam int RX_OVF  = 4;
  localparam int WAKE    = 5;
  localparam int EXT     = 6;
  localparam int LOW_BAT = 7;

  // bits cleared by a status read
  localparam logic [SRC_N-1:0] RTC_MASK = 8'b1011_1100;

  typedef struct packed {
    logic [SRC_N-1:0] setVec;
    logic [SRC_N-1:0] clrVec;
    logic             capture;
  } irqStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEn,
  input  logic               txChainEn,
  input  logic               fifoEn,
  input  logic               rxChainEn,
  input  logic               wakeEn,
  input  logic               battEn,
  input  logic               extMode,
  input  logic               txEmptyEvt,
  input  logic               txUnderEvt,
  input  logic               txWrite,
  input  logic               rxLevelEvt,
  input  logic               rxOverEvt,
  input  logic               rxDrained,
  input  logic               porPulse,
  input  logic               swResetPulse,
  input  logic               wakeEvt,
  input  logic               extPin,
  input  logic [LEVEL_W-1:0] supplyLevel,
  input  logic [LEVEL_W-1:0] battThresh,
  input  logic               statusRd,
  input  logic [SRC_N-1:0]   statusQ,
  output irqStrobes_t        strobes
);
  logic             rdPendQ;
  logic [SRC_N-1:0] snapQ;
  logic             txOn, rxOn;

  assign txOn = txEn && txChainEn;
  assign rxOn = fifoEn && rxChainEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPendQ <= 1'b0;
      snapQ   <= '0;
    end else begin
      rdPendQ <= statusRd;
      snapQ   <= statusRd ? statusQ : '0;
    end
  end

  always_comb begin
    strobes.setVec          = '0;
    strobes.setVec[TX_RDY]  = txOn && txEmptyEvt;
    strobes.setVec[RX_THR]  = rxOn && rxLevelEvt;
    strobes.setVec[RST_DET] = porPulse || swResetPulse;
    strobes.setVec[TX_UND]  = txOn && txUnderEvt;
    strobes.setVec[RX_OVF]  = rxOn && rxOverEvt;
    strobes.setVec[WAKE]    = wakeEn && wakeEvt;
    strobes.setVec[EXT]     = extMode && extPin;
    strobes.setVec[LOW_BAT] = battEn && (supplyLevel < battThresh);

    strobes.clrVec          = rdPendQ ? (snapQ & RTC_MASK) : '0;
    strobes.clrVec[TX_RDY]  = txWrite || !txOn;
    strobes.clrVec[RX_THR]  = rxDrained || !rxOn;
    strobes.clrVec[EXT]     = 1'b1;

    strobes.capture         = statusRd;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqStrobes_t      strobes,
  output logic [SRC_N-1:0] statusQ,
  output logic [SRC_N-1:0] rdDataQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      rdDataQ <= '0;
    end else begin
      statusQ <= (statusQ & ~strobes.clrVec) | strobes.setVec;
      if (strobes.capture) rdDataQ <= statusQ;
    end
  end

  for (genvar i = 0; i < SRC_N; i++) begin : g_setChk
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobes.setVec[i] |=> statusQ[i]);
  end

  // R10
  capture_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> rdDataQ == $past(statusQ));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEn,
  input  logic               txChainEn,
  input  logic               fifoEn,
  input  logic               rxChainEn,
  input  logic               wakeEn,
  input  logic               battEn,
  input  logic               extMode,
  input  logic               txEmptyEvt,
  input  logic               txUnderEvt,
  input  logic               txWrite,
  input  logic               rxLevelEvt,
  input  logic               rxOverEvt,
  input  logic               rxDrained,
  input  logic               porPulse,
  input  logic               swResetPulse,
  input  logic               wakeEvt,
  input  logic               extPin,
  input  logic [LEVEL_W-1:0] supplyLevel,
  input  logic [LEVEL_W-1:0] battThresh,
  input  logic               statusRd,
  output logic               irqN,
  output logic [SRC_N-1:0]   statusOut,
  output logic [SRC_N-1:0]   rdData
);
  irqStrobes_t      strobes;
  logic [SRC_N-1:0] statusQ;

  irq_ctrl #(.LEVEL_W(LEVEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txEn(txEn), .txChainEn(txChainEn), .fifoEn(fifoEn), .rxChainEn(rxChainEn),
    .wakeEn(wakeEn), .battEn(battEn), .extMode(extMode),
    .txEmptyEvt(txEmptyEvt), .txUnderEvt(txUnderEvt), .txWrite(txWrite),
    .rxLevelEvt(rxLevelEvt), .rxOverEvt(rxOverEvt), .rxDrained(rxDrained),
    .porPulse(porPulse), .swResetPulse(swResetPulse), .wakeEvt(wakeEvt),
    .extPin(extPin), .supplyLevel(supplyLevel), .battThresh(battThresh),
    .statusRd(statusRd), .statusQ(statusQ), .strobes(strobes)
  );

  irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .statusQ(statusQ), .rdDataQ(rdData)
  );

  assign statusOut = statusQ;
  assign irqN      = ~(|statusQ);

  // R5
  rst_det_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[RST_DET]) |-> $past(statusRd, 2));

  // R8
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> statusOut[EXT] == $past(extMode && extPin));

  // R7
  wake_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOut[WAKE]) |-> $past(wakeEn && wakeEvt));
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
  logic clk = 0;
  logic rstN;
  logic txEn, txChainEn, fifoEn, rxChainEn, wakeEn, battEn, extMode;
  logic txEmptyEvt, txUnderEvt, txWrite, rxLevelEvt, rxOverEvt, rxDrained;
  logic porPulse, swResetPulse, wakeEvt, extPin, statusRd;
  logic [3:0] supplyLevel, battThresh;
  logic irqN;
  logic [7:0] statusOut, rdData;

  int checks = 0, fails = 0;
  logic [7:0] mSt, mRd, mSnap;
  logic mPend;
  string reqTag [8];

  always #4 clk = ~clk;

  irq_status_ctrl uut (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic allIdle();
    {txEmptyEvt, txUnderEvt, txWrite, rxLevelEvt, rxOverEvt, rxDrained} = '0;
    {porPulse, swResetPulse, wakeEvt, extPin, statusRd} = '0;
    supplyLevel = 4'hF; battThresh = 4'h0;
  endtask

  // advance one edge against the requirement model, then compare
  task automatic cycle();
    logic [7:0] setV, clrV, nxt;
    logic txOn, rxOn;
    txOn = txEn & txChainEn;
    rxOn = fifoEn & rxChainEn;
    setV = '0; clrV = '0;
    setV[0] = txOn & txEmptyEvt;                       // R3
    setV[1] = rxOn & rxLevelEvt;                       // R4
    setV[2] = porPulse | swResetPulse;                 // R5
    setV[3] = txOn & txUnderEvt;                       // R6
    setV[4] = rxOn & rxOverEvt;                        // R6
    setV[5] = wakeEn & wakeEvt;                        // R7
    setV[6] = extMode & extPin;                        // R8
    setV[7] = battEn & (supplyLevel < battThresh);     // R9
    if (mPend) clrV = mSnap & 8'b1011_1100;            // R10
    clrV[0] = txWrite | ~txOn;
    clrV[1] = rxDrained | ~rxOn;
    clrV[6] = 1'b1;
    nxt = (mSt & ~clrV) | setV;                        // R11
    if (statusRd) mRd = mSt;
    mSnap = statusRd ? mSt : 8'h00;
    mPend = statusRd;
    mSt = nxt;
    @(posedge clk); #2;
    for (int i = 0; i < 8; i++)
      chk(reqTag[i], {7'b0, statusOut[i]}, {7'b0, mSt[i]});
    chk("R2", {7'b0, irqN}, {7'b0, ~(|mSt)});
    chk("R10", rdData, mRd);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1 > 0 ? checks - fails + 1 : 0, checks + 1);
    $finish;
  end

  initial begin
    reqTag[0] = "R3"; reqTag[1] = "R4"; reqTag[2] = "R5"; reqTag[3] = "R6";
    reqTag[4] = "R6"; reqTag[5] = "R7"; reqTag[6] = "R8"; reqTag[7] = "R9";
    rstN = 0;
    {txEn, txChainEn, fifoEn, rxChainEn, wakeEn, battEn, extMode} = '0;
    allIdle();
    porPulse = 1; extMode = 1; extPin = 1;
    repeat (3) @(posedge clk);
    #2;
    // R1
    chk("R1", statusOut, 8'h00);
    chk("R1", {7'b0, irqN}, 8'h01);
    chk("R1", rdData, 8'h00);
    allIdle(); extMode = 0;
    mSt = 0; mRd = 0; mSnap = 0; mPend = 0;
    rstN = 1;
    @(posedge clk); #2;

    // R5: reset detect stays without reads, then read clears it
    porPulse = 1; cycle(); porPulse = 0;
    repeat (4) cycle();
    chk("R5", {7'b0, statusOut[2]}, 8'h01);
    statusRd = 1; cycle(); statusRd = 0;
    chk("R10", rdData, 8'h04);
    cycle();
    chk("R5", {7'b0, statusOut[2]}, 8'h00);

    // R11: event and write in the same edge
    txEn = 1; txChainEn = 1;
    txEmptyEvt = 1; txWrite = 1; cycle();
    chk("R11", {7'b0, statusOut[0]}, 8'h01);
    txEmptyEvt = 0; txWrite = 1; cycle(); txWrite = 0;
    chk("R3", {7'b0, statusOut[0]}, 8'h00);

    // R10: bit set during capture edge survives the clear
    wakeEn = 1; wakeEvt = 1; cycle(); wakeEvt = 0;
    statusRd = 1; battEn = 1; supplyLevel = 2; battThresh = 5; cycle();
    statusRd = 0; battEn = 0; cycle();
    chk("R10", {7'b0, statusOut[7]}, 8'h01);
    chk("R7", {7'b0, statusOut[5]}, 8'h00);

    // R9: full sweep of the 4-bit comparison, reading each step
    battEn = 1; statusRd = 1;
    for (int t = 0; t < 16; t++)
      for (int l = 0; l < 16; l++) begin
        battThresh = 4'(t); supplyLevel = 4'(l);
        cycle();
      end
    allIdle(); battEn = 0;
    repeat (3) cycle();

    // mixed random sweep over enables, events and clears
    for (int n = 0; n < 4000; n++) begin
      txEn = ($urandom_range(0, 7) != 0); txChainEn = ($urandom_range(0, 7) != 0);
      fifoEn = ($urandom_range(0, 7) != 0); rxChainEn = ($urandom_range(0, 7) != 0);
      wakeEn = ($urandom_range(0, 3) != 0); battEn = ($urandom_range(0, 3) != 0);
      extMode = ($urandom_range(0, 1) != 0); extPin = ($urandom_range(0, 1) != 0);
      txEmptyEvt = ($urandom_range(0, 5) == 0); txUnderEvt = ($urandom_range(0, 7) == 0);
      txWrite = ($urandom_range(0, 5) == 0); rxLevelEvt = ($urandom_range(0, 5) == 0);
      rxOverEvt = ($urandom_range(0, 7) == 0); rxDrained = ($urandom_range(0, 5) == 0);
      porPulse = ($urandom_range(0, 15) == 0); swResetPulse = ($urandom_range(0, 15) == 0);
      wakeEvt = ($urandom_range(0, 7) == 0); statusRd = ($urandom_range(0, 5) == 0);
      supplyLevel = 4'($urandom_range(0, 15)); battThresh = 4'($urandom_range(0, 15));
      cycle();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule